// File: doc/BRIEF.md
# Two-Channel Parallel Port Register File

This block is the processor-facing register file of a two-channel parallel interface adapter. Each channel owns an 8-bit output latch, an 8-bit direction register and a control register. A synchronous CPU bus reaches these registers through three chip-select inputs, a 2-bit register select, a read/write line and separate 8-bit write and read data paths. Only four addresses exist for six registers. On each channel the port address is shared between the direction register and the output latch. Bit 2 of that channel's control register decides which of the two the CPU sees.

On the pin side, each channel has an input vector, an output vector that always carries the latch, and an output-enable vector equal to the direction register. A read of the output latch returns a mix: latched values for pins set as outputs, live pin levels for pins set as inputs. Control bits 7 and 6 are status flags that the companion edge-detection block produces. This block passes them to the bus on reads. It also gives that block a one-cycle strobe for each control-register read, so the companion can clear the flags. The low six control bits are exported to the companion as its setup.

Top module: `pario_regs`

## Requirements
- R1: Register select 0 addresses channel A's port register, 1 addresses control A, 2 addresses channel B's port register and 3 addresses control B. Bit 1 of the select picks the channel and bit 0 picks control (1) or port (0). An access to one channel never changes the other channel's registers or pins.
- R2: The block is selected only in a cycle where `cs_hi0`=1, `cs_hi1`=1 and `cs_lo_n`=0. With any one of these at its inactive level, a write changes no register and a read returns nothing (`rdata_oe` stays 0).
- R3: When bit 2 of a channel's control register is 0, its port address reads and writes the direction register. When that bit is 1, the port address reads and writes the output latch.
- R4: A direction bit of 1 makes the matching pin an output (`px_oe` bit 1) and 0 makes it an input. Any mix of inputs and outputs is allowed. `px_out` always carries the output latch, and only pins with `px_oe`=1 drive it.
- R5: A read of the output latch returns, per bit, the latch value where the direction bit is 1 and the live `px_in` level where it is 0. Pin inputs are followed whether or not the block is selected.
- R6: Control bits 5..0 are written and read back by the CPU and appear on `ctl_a`/`ctl_b`. A control read returns bits 7 and 6 from `flag_a`/`flag_b` (index 1 to bit 7). Writes to bits 7 and 6 are ignored.
- R7: Reset (synchronous, active high) clears the direction registers, the output latches and the control registers of both channels to zero. All pins become inputs and all setup bits are zero.
- R8: A selected read in one cycle puts its value on `rdata` with `rdata_oe`=1 in the following cycle only. In every other cycle `rdata_oe` is 0 and `rdata` is zero.
- R9: A selected read of a control register raises that channel's `ctl_rd_a`/`ctl_rd_b` for exactly the cycle in which `rdata_oe` is 1, and never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_hi0 | input | 1 | Chip select, active high |
| cs_hi1 | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| rsel | input | 2 | Register select |
| rnw | input | 1 | 1 = read, 0 = write |
| wdata | input | 8 | Write data from the CPU |
| rdata | output | 8 | Read data to the CPU, zero when not driven |
| rdata_oe | output | 1 | Read data valid / bus drive enable |
| pa_in | input | 8 | Channel A pin levels |
| pa_out | output | 8 | Channel A output latch |
| pa_oe | output | 8 | Channel A per-pin output enable |
| pb_in | input | 8 | Channel B pin levels |
| pb_out | output | 8 | Channel B output latch |
| pb_oe | output | 8 | Channel B per-pin output enable |
| flag_a | input | 2 | Channel A status flags for control bits 7..6 |
| flag_b | input | 2 | Channel B status flags for control bits 7..6 |
| ctl_a | output | 6 | Channel A control setup bits 5..0 |
| ctl_b | output | 6 | Channel B control setup bits 5..0 |
| ctl_rd_a | output | 1 | Strobe: control A was read |
| ctl_rd_b | output | 1 | Strobe: control B was read |

## Verification
The assertions assume that bus inputs are stable across each rising edge and that the bus stays deselected while reset is high. Under that assumption, every past-cycle check after reset starts from a quiet bus. The bench changes every bus and pin input only on falling edges and keeps the chip selects inactive through reset. Each access leaves the block deselected again, so every read-data pulse can be traced to exactly one selected read.

// File: rtl/pario_pkg.sv
package pario_pkg;

    localparam int DATA_W   = 8;
    localparam int FLAG_W   = 2;
    localparam int SETUP_W  = DATA_W - FLAG_W;
    localparam int NUM_CH   = 2;
    localparam int RSEL_W   = 2;
    localparam int SEL_BIT  = 2;   // control bit choosing latch (1) or direction (0)

    typedef enum logic {
        KIND_PORT = 1'b0,
        KIND_CTRL = 1'b1
    } reg_kind_e;

    typedef struct packed {
        logic              hit;
        logic              rd;
        logic              wr;
        logic              ch;
        reg_kind_e         kind;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic [FLAG_W-1:0]  flags;
        logic [SETUP_W-1:0] setup;
    } ctrl_word_t;

    function automatic logic [DATA_W-1:0] mix_pins(
        input logic [DATA_W-1:0] latch,
        input logic [DATA_W-1:0] dir,
        input logic [DATA_W-1:0] pins
    );
        return (latch & dir) | (pins & ~dir);
    endfunction

endpackage

// File: rtl/pario_decode.sv
module pario_decode
    import pario_pkg::*;
(
    input  logic              cs_hi0,
    input  logic              cs_hi1,
    input  logic              cs_lo_n,
    input  logic [RSEL_W-1:0] rsel,
    input  logic              rnw,
    input  logic [DATA_W-1:0] wdata,
    output bus_req_t          req
);

    logic selected;

    always_comb begin
        selected  = cs_hi0 & cs_hi1 & ~cs_lo_n;
        req.hit   = selected;
        req.rd    = selected & rnw;
        req.wr    = selected & ~rnw;
        req.ch    = rsel[1];
        req.kind  = rsel[0] ? KIND_CTRL : KIND_PORT;
        req.wdata = wdata;
    end

endmodule

// File: rtl/pario_channel.sv
module pario_channel
    import pario_pkg::*;
#(
    parameter int CH_ID = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_req_t           req,
    input  logic [DATA_W-1:0]  pin_in,
    input  logic [FLAG_W-1:0]  flags,
    output logic [DATA_W-1:0]  pin_out,
    output logic [DATA_W-1:0]  pin_oe,
    output logic [SETUP_W-1:0] setup,
    output logic [DATA_W-1:0]  rd_word,
    output logic               ctl_rd
);

    logic              mine;
    logic              ctl_wr;
    logic              port_wr;
    logic              dir_wr;
    logic              lat_wr;
    logic [DATA_W-1:0] dir_q;
    logic [DATA_W-1:0] lat_q;
    ctrl_word_t        ctl_q;

    always_comb begin
        mine    = req.hit && (req.ch == CH_ID[0]);
        ctl_wr  = mine && req.wr && (req.kind == KIND_CTRL);
        port_wr = mine && req.wr && (req.kind == KIND_PORT);
        dir_wr  = port_wr && !ctl_q.setup[SEL_BIT];
        lat_wr  = port_wr &&  ctl_q.setup[SEL_BIT];
        ctl_rd  = mine && req.rd && (req.kind == KIND_CTRL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q       <= '0;
            lat_q       <= '0;
            ctl_q.setup <= '0;
        end else begin
            if (dir_wr) dir_q       <= req.wdata;
            if (lat_wr) lat_q       <= req.wdata;
            if (ctl_wr) ctl_q.setup <= req.wdata[SETUP_W-1:0];
        end
    end

    always_comb ctl_q.flags = flags;

    always_comb begin
        if (req.kind == KIND_CTRL)
            rd_word = ctl_q;
        else if (ctl_q.setup[SEL_BIT])
            rd_word = mix_pins(lat_q, dir_q, pin_in);
        else
            rd_word = dir_q;
    end

    assign pin_out = lat_q;
    assign pin_oe  = dir_q;
    assign setup   = ctl_q.setup;

    AST_OE_HOLDS_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(mine && req.wr && req.kind == KIND_PORT && !setup[SEL_BIT]) |=> $stable(pin_oe)); // R3

    AST_OUT_HOLDS_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(mine && req.wr && req.kind == KIND_PORT && setup[SEL_BIT]) |=> $stable(pin_out)); // R3

    AST_SETUP_HOLDS_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(req.hit && req.wr && req.ch == CH_ID[0] && req.kind == KIND_CTRL) |=> $stable(setup)); // R6

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (pin_oe == '0 && pin_out == '0 && setup == '0)); // R7

endmodule

// File: rtl/pario_regs.sv
module pario_regs
    import pario_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_hi0,
    input  logic               cs_hi1,
    input  logic               cs_lo_n,
    input  logic [RSEL_W-1:0]  rsel,
    input  logic               rnw,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               rdata_oe,
    input  logic [DATA_W-1:0]  pa_in,
    output logic [DATA_W-1:0]  pa_out,
    output logic [DATA_W-1:0]  pa_oe,
    input  logic [DATA_W-1:0]  pb_in,
    output logic [DATA_W-1:0]  pb_out,
    output logic [DATA_W-1:0]  pb_oe,
    input  logic [FLAG_W-1:0]  flag_a,
    input  logic [FLAG_W-1:0]  flag_b,
    output logic [SETUP_W-1:0] ctl_a,
    output logic [SETUP_W-1:0] ctl_b,
    output logic               ctl_rd_a,
    output logic               ctl_rd_b
);

    bus_req_t                               req;
    logic [NUM_CH-1:0][DATA_W-1:0]          pin_in_v;
    logic [NUM_CH-1:0][DATA_W-1:0]          pin_out_v;
    logic [NUM_CH-1:0][DATA_W-1:0]          pin_oe_v;
    logic [NUM_CH-1:0][FLAG_W-1:0]          flag_v;
    logic [NUM_CH-1:0][SETUP_W-1:0]         setup_v;
    logic [NUM_CH-1:0][DATA_W-1:0]          rd_word_v;
    logic [NUM_CH-1:0]                      ctl_rd_v;
    logic [NUM_CH-1:0]                      ctl_rd_q;

    pario_decode u_decode (
        .cs_hi0  (cs_hi0),
        .cs_hi1  (cs_hi1),
        .cs_lo_n (cs_lo_n),
        .rsel    (rsel),
        .rnw     (rnw),
        .wdata   (wdata),
        .req     (req)
    );

    assign pin_in_v[0] = pa_in;
    assign pin_in_v[1] = pb_in;
    assign flag_v[0]   = flag_a;
    assign flag_v[1]   = flag_b;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pario_channel #(.CH_ID(c)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .req     (req),
            .pin_in  (pin_in_v[c]),
            .flags   (flag_v[c]),
            .pin_out (pin_out_v[c]),
            .pin_oe  (pin_oe_v[c]),
            .setup   (setup_v[c]),
            .rd_word (rd_word_v[c]),
            .ctl_rd  (ctl_rd_v[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata    <= '0;
            rdata_oe <= 1'b0;
            ctl_rd_q <= '0;
        end else if (req.rd) begin
            rdata    <= rd_word_v[req.ch];
            rdata_oe <= 1'b1;
            ctl_rd_q <= ctl_rd_v;
        end else begin
            rdata    <= '0;
            rdata_oe <= 1'b0;
            ctl_rd_q <= '0;
        end
    end

    assign pa_out   = pin_out_v[0];
    assign pa_oe    = pin_oe_v[0];
    assign pb_out   = pin_out_v[1];
    assign pb_oe    = pin_oe_v[1];
    assign ctl_a    = setup_v[0];
    assign ctl_b    = setup_v[1];
    assign ctl_rd_a = ctl_rd_q[0];
    assign ctl_rd_b = ctl_rd_q[1];

    AST_OE_FROM_SELECTED_READ: assert property (@(posedge clk) disable iff (rst)
        rdata_oe |-> $past(cs_hi0 && cs_hi1 && !cs_lo_n && rnw)); // R2

    AST_BUS_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rdata_oe |-> (rdata == '0)); // R8

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl_rd_a, ctl_rd_b})); // R9

    AST_STROBE_A_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        ctl_rd_a |-> (rdata_oe && $past(rsel == 2'd1))); // R1

    AST_STROBE_B_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        ctl_rd_b |-> (rdata_oe && $past(rsel == 2'd3))); // R1

endmodule

// File: tb/pario_regs_bench.sv
module pario_regs_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       cs_hi0, cs_hi1, cs_lo_n;
    logic [1:0] rsel;
    logic       rnw;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       rdata_oe;
    logic [7:0] pa_in, pa_out, pa_oe;
    logic [7:0] pb_in, pb_out, pb_oe;
    logic [1:0] flag_a, flag_b;
    logic [5:0] ctl_a, ctl_b;
    logic       ctl_rd_a, ctl_rd_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    pario_regs u_pario_regs (
        .clk(clk), .rst(rst), .cs_hi0(cs_hi0), .cs_hi1(cs_hi1), .cs_lo_n(cs_lo_n),
        .rsel(rsel), .rnw(rnw), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .flag_a(flag_a), .flag_b(flag_b), .ctl_a(ctl_a), .ctl_b(ctl_b),
        .ctl_rd_a(ctl_rd_a), .ctl_rd_b(ctl_rd_b)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic deselect();
        cs_hi0 = 1'b0; cs_hi1 = 1'b1; cs_lo_n = 1'b1; rnw = 1'b1;
    endtask

    task automatic bus_wr(input logic [1:0] rs, input logic [7:0] d);
        @(negedge clk);
        cs_hi0 = 1'b1; cs_hi1 = 1'b1; cs_lo_n = 1'b0; rsel = rs; rnw = 1'b0; wdata = d;
        @(negedge clk);
        deselect();
    endtask

    task automatic bus_rd(input logic [1:0] rs, output logic [7:0] d, output logic oe,
                          output logic sa, output logic sb);
        @(negedge clk);
        cs_hi0 = 1'b1; cs_hi1 = 1'b1; cs_lo_n = 1'b0; rsel = rs; rnw = 1'b1;
        @(negedge clk);
        d = rdata; oe = rdata_oe; sa = ctl_rd_a; sb = ctl_rd_b;
        deselect();
    endtask

    task automatic t_reset();
        logic [7:0] d; logic oe, sa, sb;
        check("R7 pa_oe", pa_oe, 8'h00);
        check("R7 pb_oe", pb_oe, 8'h00);
        check("R7 pa_out", pa_out, 8'h00);
        check("R7 ctl_a", {2'b00, ctl_a}, 8'h00);
        check("R7 ctl_b", {2'b00, ctl_b}, 8'h00);
        check("R8 idle oe", {7'd0, rdata_oe}, 8'h00);
        bus_rd(2'd0, d, oe, sa, sb);
        check("R7 dir A reads zero", d, 8'h00);
        check("R8 read oe", {7'd0, oe}, 8'h01);
    endtask

    task automatic t_port_a();
        logic [7:0] d; logic oe, sa, sb;
        bus_wr(2'd1, 8'h00);
        bus_wr(2'd0, 8'h0F);
        check("R4 pa_oe after dir write", pa_oe, 8'h0F);
        check("R3 latch untouched by dir write", pa_out, 8'h00);
        bus_wr(2'd1, 8'h04);
        bus_wr(2'd0, 8'hA5);
        check("R3 dir untouched by latch write", pa_oe, 8'h0F);
        check("R4 pa_out carries latch", pa_out, 8'hA5);
        pa_in = 8'h3C;
        bus_rd(2'd0, d, oe, sa, sb);
        check("R5 mixed read A", d, 8'h35);
        check("R1 pb untouched", pb_oe, 8'h00);
        bus_wr(2'd1, 8'h00);
        bus_rd(2'd0, d, oe, sa, sb);
        check("R3 port addr reads dir", d, 8'h0F);
        check("R9 no strobe on port read", {6'd0, sa, sb}, 8'h00);
    endtask

    task automatic t_port_b();
        logic [7:0] d; logic oe, sa, sb;
        bus_wr(2'd3, 8'h04);
        bus_wr(2'd2, 8'h77);
        check("R4 latch B not driven", pb_oe, 8'h00);
        check("R4 pb_out latch", pb_out, 8'h77);
        bus_wr(2'd3, 8'h00);
        bus_wr(2'd2, 8'hF0);
        check("R3 dir B", pb_oe, 8'hF0);
        bus_wr(2'd3, 8'h04);
        pb_in = 8'h5A;
        bus_rd(2'd2, d, oe, sa, sb);
        check("R5 mixed read B", d, 8'h7A);
        check("R1 A untouched by B", pa_oe, 8'h0F);
        check("R1 A latch kept", pa_out, 8'hA5);
    endtask

    task automatic t_control();
        logic [7:0] d; logic oe, sa, sb;
        flag_a = 2'b10;
        bus_wr(2'd1, 8'hFF);
        check("R6 setup A written", {2'b00, ctl_a}, 8'h3F);
        bus_rd(2'd1, d, oe, sa, sb);
        check("R6 ctrl A read flags+setup", d, 8'hBF);
        check("R9 strobe A", {6'd0, sa, sb}, 8'h02);
        flag_b = 2'b01;
        bus_rd(2'd3, d, oe, sa, sb);
        check("R6 ctrl B read", d, 8'h44);
        check("R9 strobe B", {6'd0, sa, sb}, 8'h01);
        bus_wr(2'd3, 8'hC4);
        check("R6 flag bits write ignored", {2'b00, ctl_b}, 8'h04);
        flag_b = 2'b00;
        bus_rd(2'd3, d, oe, sa, sb);
        check("R6 flags follow input", d, 8'h04);
    endtask

    task automatic t_chip_select();
        logic [7:0] d; logic oe, sa, sb;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            cs_hi0 = (k != 0); cs_hi1 = (k != 1); cs_lo_n = (k == 2);
            rsel = 2'd1; rnw = 1'b0; wdata = 8'h00;
            @(negedge clk);
            deselect();
            check("R2 partial select write ignored", {2'b00, ctl_a}, 8'h3F);
            @(negedge clk);
            cs_hi0 = (k != 0); cs_hi1 = (k != 1); cs_lo_n = (k == 2);
            rsel = 2'd0; rnw = 1'b1;
            @(negedge clk);
            check("R2 partial select no read", {7'd0, rdata_oe}, 8'h00);
            deselect();
        end
        bus_rd(2'd1, d, oe, sa, sb);
        check("R2 full select reads", {7'd0, oe}, 8'h01);
    endtask

    task automatic t_idle();
        logic [7:0] d; logic oe, sa, sb;
        pa_in = 8'hFF;
        bus_rd(2'd0, d, oe, sa, sb);
        check("R5 live pins after deselect", d, 8'hF5);
        @(negedge clk);
        check("R8 oe drops", {7'd0, rdata_oe}, 8'h00);
        check("R8 rdata zero", rdata, 8'h00);
        check("R9 strobes drop", {6'd0, ctl_rd_a, ctl_rd_b}, 8'h00);
    endtask

    task automatic t_reset_again();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R7 pa_oe cleared", pa_oe, 8'h00);
        check("R7 pb_out cleared", pb_out, 8'h00);
        check("R7 ctl_a cleared", {2'b00, ctl_a}, 8'h00);
        check("R7 ctl_b cleared", {2'b00, ctl_b}, 8'h00);
    endtask

    initial begin
        rst = 1'b1; deselect(); rsel = 2'd0; wdata = 8'h00;
        pa_in = 8'h00; pb_in = 8'h00; flag_a = 2'b00; flag_b = 2'b00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_port_a();
        t_port_b();
        t_control();
        t_chip_select();
        t_idle();
        t_reset_again();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule